// File: doc/BRIEF.md
# Vector Issue Scoreboard with Chaining

This block is the issue stage of a register-based vector processor. Each incoming instruction is a vector add or a vector multiply. It names a destination and two source registers out of eight vector registers. The stage issues at most one instruction per clock. It holds an instruction back while its functional unit, its destination or one of its sources is not ready. Later instructions never pass a stalled one.

Once issued, an instruction keeps its pipeline busy for one cycle per element. It launches one element per cycle and writes each result a fixed number of cycles later: three for add, four for multiply. A consumer whose source is still being written does not wait for the whole vector. It may issue in the cycle after the producer writes element 0. Because producer and consumer both advance one element per cycle, element k is always read after it is written. Several vector instructions can therefore be in flight while issue stays at one per cycle. The outputs are per-element launch and write strobes for each pipeline.

A vector-length register sets the element count of every issued instruction.

Top module: `vsb_issue`

## Requirements
- R1: At most one instruction issues per cycle. `pc_o` starts at 0 and rises by exactly one in the cycle after each issue.
- R2: Registers are numbered 0 to 7 by 3-bit fields. Every element write reports the destination register of its own instruction.
- R3: The length register `vlen_i` is loaded when `vlen_we_i` is high. A loaded value of 0, which is also the reset value, means 64 elements; values 1 to 63 mean that many elements. An instruction issued in the same cycle as a load uses the old length.
- R4: An instruction issued in cycle c launches elements 0 to n-1 on its unit in cycles c+1 to c+n, one per cycle, with the index on `*_rd_idx_o`.
- R5: The add pipeline writes element k in cycle c+3+k.
- R6: The multiply pipeline writes element k in cycle c+4+k.
- R7: Each unit holds one instruction at a time. A second instruction for the same unit issues no earlier than n cycles after the first, which is the cycle of the first one's last launch.
- R8: A consumer whose source is being written issues in the cycle after the producer writes element 0. That is 4 cycles after an add producer and 5 cycles after a multiply producer.
- R9: An instruction whose destination still has writes outstanding waits until the cycle after the last of those writes. That is 3+n cycles after an add writer and 4+n after a multiply writer. The two pipelines never write the same register in the same cycle.
- R10: A stalled instruction holds its place and `pc_o` holds. Independent instructions on different units issue in consecutive cycles.
- R11: A chained consumer never reads element k of a source before the producer has written element k of it.
- R12: After reset the block drives no launch or write strobes and `pc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vlen_we_i | input | 1 | Load the vector-length register |
| vlen_i | input | 6 | New vector length, 0 means 64 |
| instr_valid_i | input | 1 | Instruction present |
| instr_op_i | input | 1 | 0 add, 1 multiply |
| instr_dst_i | input | 3 | Destination register |
| instr_src_a_i | input | 3 | First source register |
| instr_src_b_i | input | 3 | Second source register |
| issue_o | output | 1 | Instruction accepted this cycle |
| pc_o | output | 16 | Count of issued instructions |
| add_rd_o | output | 1 | Add pipeline launches an element |
| add_rd_idx_o | output | 6 | Index of launched add element |
| add_wr_o | output | 1 | Add pipeline writes an element |
| add_wr_dst_o | output | 3 | Register written by add |
| add_wr_idx_o | output | 6 | Index of element written by add |
| mul_rd_o | output | 1 | Multiply pipeline launches an element |
| mul_rd_idx_o | output | 6 | Index of launched multiply element |
| mul_wr_o | output | 1 | Multiply pipeline writes an element |
| mul_wr_dst_o | output | 3 | Register written by multiply |
| mul_wr_idx_o | output | 6 | Index of element written by multiply |

## Verification
Every result has a fixed delay from its issue cycle c. Element k is launched in cycle c+1+k and written in cycle c+3+k for add or c+4+k for multiply. A stalled second instruction issues a fixed gap after the first: n for the same unit, 4 or 5 for chaining, and 3+n or 4+n for a destination conflict. The bench counts cycles itself. It drives and samples on the falling edge, records each observed issue cycle, and compares every launch, every write and every issue gap against these offsets. It also tags each element write with the writer it belongs to, so that each chained read can be checked against the producer's write of that same element.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  localparam int ADD_LAT = 3;
  localparam int MUL_LAT = 4;
  localparam int NUM_FU  = 2;

  typedef enum logic {OP_ADD = 1'b0, OP_MUL = 1'b1} vop_e;

  function automatic int fu_lat(int u);
    return (u == 0) ? ADD_LAT : MUL_LAT;
  endfunction
endpackage

// File: rtl/vsb_fu.sv
module vsb_fu #(
  parameter int LAT   = 3,
  parameter int IDX_W = 6,
  parameter int REG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W:0]   len_i,
  input  logic [REG_W-1:0] dst_i,
  output logic             free_o,
  output logic             rd_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wr_o,
  output logic [REG_W-1:0] wr_dst_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             wr_last_o
);
  localparam int DEPTH = LAT - 1;
  localparam logic [IDX_W:0] ONE = (IDX_W+1)'(1);

  logic [IDX_W:0]   cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [REG_W-1:0] dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
      dst_q <= '0;
    end else if (start_i) begin
      cnt_q <= len_i;
      idx_q <= '0;
      dst_q <= dst_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
      idx_q <= idx_q + 1'b1;
    end
  end

  // free while launching the final element: back-to-back vectors
  assign free_o   = (cnt_q <= ONE);
  assign rd_o     = (cnt_q != '0);
  assign rd_idx_o = idx_q;

  logic [DEPTH-1:0]            v_q, l_q;
  logic [DEPTH-1:0][REG_W-1:0] d_q;
  logic [DEPTH-1:0][IDX_W-1:0] i_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      l_q <= '0;
      d_q <= '0;
      i_q <= '0;
    end else begin
      v_q[0] <= rd_o;
      l_q[0] <= (cnt_q == ONE);
      d_q[0] <= dst_q;
      i_q[0] <= idx_q;
      for (int s = 1; s < DEPTH; s++) begin
        v_q[s] <= v_q[s-1];
        l_q[s] <= l_q[s-1];
        d_q[s] <= d_q[s-1];
        i_q[s] <= i_q[s-1];
      end
    end
  end

  assign wr_o      = v_q[DEPTH-1];
  assign wr_last_o = v_q[DEPTH-1] & l_q[DEPTH-1];
  assign wr_dst_o  = d_q[DEPTH-1];
  assign wr_idx_o  = i_q[DEPTH-1];
endmodule

// File: rtl/vsb_regtrack.sv
module vsb_regtrack #(
  parameter int NREG  = 8,
  parameter int REG_W = 3,
  parameter int IDX_W = 6,
  parameter int NFU   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      issue_i,
  input  logic [REG_W-1:0]          issue_dst_i,
  input  logic [NFU-1:0]            wr_i,
  input  logic [NFU-1:0][REG_W-1:0] wr_dst_i,
  input  logic [NFU-1:0][IDX_W-1:0] wr_idx_i,
  input  logic [NFU-1:0]            wr_last_i,
  output logic [NREG-1:0]           pend_o,
  output logic [NREG-1:0]           chain_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit_first, hit_last, pend_q, chain_q;

    always_comb begin
      hit_first = 1'b0;
      hit_last  = 1'b0;
      for (int u = 0; u < NFU; u++) begin
        if (wr_i[u] && wr_dst_i[u] == REG_W'(r)) begin
          if (wr_idx_i[u] == '0) hit_first = 1'b1;
          if (wr_last_i[u])      hit_last  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q  <= 1'b0;
        chain_q <= 1'b0;
      end else if (issue_i && issue_dst_i == REG_W'(r)) begin
        pend_q  <= 1'b1;
        chain_q <= 1'b0;
      end else begin
        if (hit_last)  pend_q  <= 1'b0;
        if (hit_first) chain_q <= 1'b1;
      end
    end

    assign pend_o[r]  = pend_q;
    assign chain_o[r] = chain_q;
  end
endmodule

// File: rtl/vsb_issue.sv
module vsb_issue
  import vsb_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int MAX_VL = 64,
  parameter int PC_W   = 16,
  localparam int REG_W = $clog2(NREG),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vlen_we_i,
  input  logic [IDX_W-1:0] vlen_i,
  input  logic             instr_valid_i,
  input  logic             instr_op_i,
  input  logic [REG_W-1:0] instr_dst_i,
  input  logic [REG_W-1:0] instr_src_a_i,
  input  logic [REG_W-1:0] instr_src_b_i,
  output logic             issue_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             add_rd_o,
  output logic [IDX_W-1:0] add_rd_idx_o,
  output logic             add_wr_o,
  output logic [REG_W-1:0] add_wr_dst_o,
  output logic [IDX_W-1:0] add_wr_idx_o,
  output logic             mul_rd_o,
  output logic [IDX_W-1:0] mul_rd_idx_o,
  output logic             mul_wr_o,
  output logic [REG_W-1:0] mul_wr_dst_o,
  output logic [IDX_W-1:0] mul_wr_idx_o
);
  logic [IDX_W-1:0] vl_q;
  logic [IDX_W:0]   len;
  logic [PC_W-1:0]  pc_q;
  logic [NREG-1:0]  pend, chain;
  logic             src_a_ok, src_b_ok;

  logic [NUM_FU-1:0]            fu_free, fu_start, rd_v, wr_v, wr_last;
  logic [NUM_FU-1:0][IDX_W-1:0] rd_idx, wr_idx;
  logic [NUM_FU-1:0][REG_W-1:0] wr_dst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vl_q <= '0;
    else if (vlen_we_i) vl_q <= vlen_i;
  end

  assign len = (vl_q == '0) ? (IDX_W+1)'(MAX_VL) : {1'b0, vl_q};

  // a source is usable if idle or its writer has produced element 0
  assign src_a_ok = !pend[instr_src_a_i] || chain[instr_src_a_i];
  assign src_b_ok = !pend[instr_src_b_i] || chain[instr_src_b_i];
  assign issue_o  = instr_valid_i && fu_free[instr_op_i] && !pend[instr_dst_i]
                    && src_a_ok && src_b_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (issue_o) pc_q <= pc_q + 1'b1;
  end
  assign pc_o = pc_q;

  for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
    assign fu_start[u] = issue_o && (int'(instr_op_i) == u);

    vsb_fu #(.LAT(fu_lat(u)), .IDX_W(IDX_W), .REG_W(REG_W)) u_fu (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (fu_start[u]),
      .len_i    (len),
      .dst_i    (instr_dst_i),
      .free_o   (fu_free[u]),
      .rd_o     (rd_v[u]),
      .rd_idx_o (rd_idx[u]),
      .wr_o     (wr_v[u]),
      .wr_dst_o (wr_dst[u]),
      .wr_idx_o (wr_idx[u]),
      .wr_last_o(wr_last[u])
    );
  end

  vsb_regtrack #(.NREG(NREG), .REG_W(REG_W), .IDX_W(IDX_W), .NFU(NUM_FU)) u_regtrack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue_o),
    .issue_dst_i(instr_dst_i),
    .wr_i       (wr_v),
    .wr_dst_i   (wr_dst),
    .wr_idx_i   (wr_idx),
    .wr_last_i  (wr_last),
    .pend_o     (pend),
    .chain_o    (chain)
  );

  assign add_rd_o     = rd_v[0];
  assign add_rd_idx_o = rd_idx[0];
  assign add_wr_o     = wr_v[0];
  assign add_wr_dst_o = wr_dst[0];
  assign add_wr_idx_o = wr_idx[0];
  assign mul_rd_o     = rd_v[1];
  assign mul_rd_idx_o = rd_idx[1];
  assign mul_wr_o     = wr_v[1];
  assign mul_wr_dst_o = wr_dst[1];
  assign mul_wr_idx_o = wr_idx[1];
endmodule

// File: rtl/vsb_issue_chk.sv
module vsb_issue_chk
  import vsb_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int IDX_W = 6,
  parameter int REG_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_op_i,
  input logic             issue_o,
  input logic [PC_W-1:0]  pc_o,
  input logic             add_rd_o,
  input logic [IDX_W-1:0] add_rd_idx_o,
  input logic             add_wr_o,
  input logic [REG_W-1:0] add_wr_dst_o,
  input logic [IDX_W-1:0] add_wr_idx_o,
  input logic             mul_rd_o,
  input logic [IDX_W-1:0] mul_rd_idx_o,
  input logic             mul_wr_o,
  input logic [REG_W-1:0] mul_wr_dst_o,
  input logic [IDX_W-1:0] mul_wr_idx_o
);
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> pc_o == $past(pc_o) + 1'b1); // R1

  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_o |=> $stable(pc_o)); // R10

  AST_ADD_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && instr_op_i == OP_ADD) |=> (add_rd_o && add_rd_idx_o == '0)); // R4

  AST_MUL_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && instr_op_i == OP_MUL) |=> (mul_rd_o && mul_rd_idx_o == '0)); // R4

  AST_ADD_RD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_rd_o && $past(add_rd_o) && add_rd_idx_o != '0)
      |-> add_rd_idx_o == $past(add_rd_idx_o) + 1'b1); // R4

  AST_ADD_WR_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_wr_o |-> ($past(add_rd_o, ADD_LAT-1) && add_wr_idx_o == $past(add_rd_idx_o, ADD_LAT-1))); // R5

  AST_MUL_WR_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_wr_o |-> ($past(mul_rd_o, MUL_LAT-1) && mul_wr_idx_o == $past(mul_rd_idx_o, MUL_LAT-1))); // R6

  AST_WR_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_wr_o && mul_wr_o) |-> add_wr_dst_o != mul_wr_dst_o); // R9
endmodule

bind vsb_issue vsb_issue_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/vsb_issue_bench.sv
module vsb_issue_bench;
  import vsb_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic       vlen_we, instr_valid, instr_op, issue;
  logic [5:0] vlen;
  logic [2:0] dst, src_a, src_b;
  logic [15:0] pc;
  logic       add_rd, add_wr, mul_rd, mul_wr;
  logic [5:0] add_rd_idx, add_wr_idx, mul_rd_idx, mul_wr_idx;
  logic [2:0] add_wr_dst, mul_wr_dst;

  vsb_issue u_vsb_issue (
    .clk_i(clk), .rst_ni(rst_n), .vlen_we_i(vlen_we), .vlen_i(vlen),
    .instr_valid_i(instr_valid), .instr_op_i(instr_op), .instr_dst_i(dst),
    .instr_src_a_i(src_a), .instr_src_b_i(src_b), .issue_o(issue), .pc_o(pc),
    .add_rd_o(add_rd), .add_rd_idx_o(add_rd_idx), .add_wr_o(add_wr),
    .add_wr_dst_o(add_wr_dst), .add_wr_idx_o(add_wr_idx),
    .mul_rd_o(mul_rd), .mul_rd_idx_o(mul_rd_idx), .mul_wr_o(mul_wr),
    .mul_wr_dst_o(mul_wr_dst), .mul_wr_idx_o(mul_wr_idx)
  );

  logic [1:0] rdv, wrv;
  logic [5:0] rdi [2];
  logic [5:0] wri [2];
  logic [2:0] wrd [2];
  assign rdv = {mul_rd, add_rd};
  assign wrv = {mul_wr, add_wr};
  assign rdi[0] = add_rd_idx;
  assign rdi[1] = mul_rd_idx;
  assign wri[0] = add_wr_idx;
  assign wri[1] = mul_wr_idx;
  assign wrd[0] = add_wr_dst;
  assign wrd[1] = mul_wr_dst;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, issued = 0, wcount = 0, vl_sh = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bench model state
  int gen [8];
  int glen [8];
  int wg [8][64];
  int nxt_iss [2], nxt_dst [2], nxt_a [2], nxt_b [2], nxt_ga [2], nxt_gb [2], nxt_la [2], nxt_lb [2], nxt_dg [2];
  int cur_dst [2], cur_a [2], cur_b [2], cur_ga [2], cur_gb [2], cur_la [2], cur_lb [2], cur_dg [2];
  bit hv [2][8];
  int hi [2][8], hd [2][8], hg [2][8];

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      for (int u = 0; u < 2; u++) begin
        int k, hp;
        k = int'(rdi[u]);
        hp = cyc % 8;
        if (rdv[u]) begin
          if (k == 0) begin
            cur_dst[u] = nxt_dst[u]; cur_a[u] = nxt_a[u]; cur_b[u] = nxt_b[u];
            cur_ga[u] = nxt_ga[u]; cur_gb[u] = nxt_gb[u];
            cur_la[u] = nxt_la[u]; cur_lb[u] = nxt_lb[u]; cur_dg[u] = nxt_dg[u];
            chk(cyc == nxt_iss[u] + 1, "R4", "first launch cycle", cyc, nxt_iss[u] + 1);
          end
          if (k < cur_la[u])
            chk(wg[cur_a[u]][k] == cur_ga[u], "R11", "src a element not yet written", wg[cur_a[u]][k], cur_ga[u]);
          if (k < cur_lb[u])
            chk(wg[cur_b[u]][k] == cur_gb[u], "R11", "src b element not yet written", wg[cur_b[u]][k], cur_gb[u]);
        end
        hv[u][hp] = rdv[u];
        hi[u][hp] = k;
        hd[u][hp] = cur_dst[u];
        hg[u][hp] = cur_dg[u];
      end
      for (int u = 0; u < 2; u++) begin
        if (wrv[u] && cyc >= 8) begin
          int k, lat, p;
          k = int'(wri[u]);
          lat = (u == 0) ? ADD_LAT : MUL_LAT;
          p = (cyc - (lat - 1)) % 8;
          chk(hv[u][p] && hi[u][p] == k, (u == 0) ? "R5" : "R6", "write index vs launch", k, hi[u][p]);
          chk(int'(wrd[u]) == hd[u][p], "R2", "write destination", int'(wrd[u]), hd[u][p]);
          wg[wrd[u]][k] = hg[u][p];
          wcount++;
        end
      end
      if (issue) begin
        int u, len;
        u = int'(instr_op);
        len = (vl_sh == 0) ? 64 : vl_sh;
        nxt_iss[u] = cyc; nxt_dst[u] = int'(dst);
        nxt_a[u] = int'(src_a); nxt_b[u] = int'(src_b);
        nxt_ga[u] = gen[src_a]; nxt_la[u] = glen[src_a];
        nxt_gb[u] = gen[src_b]; nxt_lb[u] = glen[src_b];
        gen[dst] = gen[dst] + 1;
        glen[dst] = len;
        nxt_dg[u] = gen[dst];
        issued++;
      end
      if (vlen_we) vl_sh = int'(vlen);
    end
  end

  task automatic send(input bit op, input int d, input int a, input int b, output int ic);
    instr_valid = 1'b1;
    instr_op = op;
    dst = 3'(d);
    src_a = 3'(a);
    src_b = 3'(b);
    #1;
    while (!issue) begin
      chk(int'(pc) == issued, "R10", "pc held while stalled", int'(pc), issued);
      @(negedge clk);
      #1;
    end
    ic = cyc;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_vl(input int v);
    vlen_we = 1'b1;
    vlen = 6'(v);
    @(negedge clk);
    vlen_we = 1'b0;
  endtask

  task automatic gap_test(input bit op1, input int d1, input int a1, input int b1,
                          input bit op2, input int d2, input int a2, input int b2,
                          input int exp, input string req);
    int c1, c2;
    send(op1, d1, a1, b1, c1);
    send(op2, d2, a2, b2, c2);
    chk(c2 - c1 == exp, req, "issue gap", c2 - c1, exp);
    idle(80);
  endtask

  initial begin
    int w0, c1, c2, c3;
    int vls [7] = '{1, 2, 3, 4, 7, 8, 16};
    rst_n = 1'b0;
    vlen_we = 1'b0; vlen = '0;
    instr_valid = 1'b0; instr_op = 1'b0; dst = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(pc == 16'd0, "R12", "pc after reset", int'(pc), 0);
    chk(!(add_rd || mul_rd || add_wr || mul_wr), "R12", "strobes after reset",
        int'({add_rd, mul_rd, add_wr, mul_wr}), 0);
    @(negedge clk);

    // reset length 0 means 64 elements
    w0 = wcount;
    gap_test(1'b0, 1, 2, 3, 1'b0, 4, 5, 6, 64, "R7");
    chk(wcount - w0 == 128, "R3", "writes at default length", wcount - w0, 128);
    gap_test(1'b0, 1, 2, 3, 1'b1, 1, 4, 5, ADD_LAT + 64, "R9");

    foreach (vls[i]) begin
      int v;
      v = vls[i];
      set_vl(v);
      w0 = wcount;
      gap_test(1'b0, 1, 2, 3, 1'b0, 4, 5, 6, v, "R7");
      gap_test(1'b1, 1, 2, 3, 1'b1, 4, 5, 6, v, "R7");
      gap_test(1'b0, 1, 2, 3, 1'b1, 4, 1, 5, ADD_LAT + 1, "R8");
      gap_test(1'b1, 2, 3, 4, 1'b0, 5, 6, 2, MUL_LAT + 1, "R8");
      gap_test(1'b0, 1, 2, 3, 1'b1, 1, 4, 5, ADD_LAT + v, "R9");
      gap_test(1'b1, 7, 0, 3, 1'b0, 7, 5, 6, MUL_LAT + v, "R9");
      gap_test(1'b0, 1, 2, 3, 1'b1, 4, 5, 6, 1, "R10");
      chk(wcount - w0 == 14 * v, "R3", "writes per length block", wcount - w0, 14 * v);
    end

    // two sums then their product
    set_vl(8);
    send(1'b0, 0, 1, 2, c1);
    send(1'b0, 3, 4, 5, c2);
    send(1'b1, 6, 0, 3, c3);
    chk(c2 - c1 == 8, "R7", "second add gap", c2 - c1, 8);
    chk(c3 - c2 == ADD_LAT + 1, "R8", "product chain gap", c3 - c2, ADD_LAT + 1);
    idle(80);

    // length load in the issue cycle applies to later instructions only
    set_vl(4);
    w0 = wcount;
    vlen_we = 1'b1;
    vlen = 6'd2;
    send(1'b0, 1, 2, 3, c1);
    vlen_we = 1'b0;
    send(1'b0, 4, 5, 6, c2);
    chk(c2 - c1 == 4, "R3", "old length used in load cycle", c2 - c1, 4);
    idle(80);
    chk(wcount - w0 == 6, "R3", "writes across length load", wcount - w0, 6);

    chk(int'(pc) == issued, "R1", "pc equals issued count", int'(pc), issued);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule